// File: doc/BRIEF.md
# Transmit Descriptor Ring Doorbell

This block holds the doorbell and status state for a set of transmit descriptor rings (64 by default). Software posts work with a register store. The store names the ring in its address, and its data gives three things: the ring slot where the post begins (the tail as it stood before the post), how many contiguous descriptors are being handed over, and a generation bit for the posted tail. The ring's tail then moves forward by that count, modulo the ring size. A store with a count of zero still wakes the ring.

A register load returns three values for the addressed ring: the head pointer of the hardware fetcher, a rolling count of completed descriptors, and the current generation. Valid descriptors are the ones that carry the inverse of that generation.

A fetcher-side port lets a consumer advance a ring's head and report completed descriptors. When the head wraps to slot zero, the generation flips. Each ring has a flush flag, and a write that clears the flag resets the ring's completed count. Each ring's size is a power of two set through a configuration port. Descriptor fetching and transmission are done elsewhere. A combinational query port exposes one ring's tail-side state to that fetcher.

Top module: `tx_ring_doorbell`

## Requirements
- R1: After reset, every ring has tail, head, completed count, generation, posted generation and flush flag at zero, and a ring size of 2^DEF_LOG2 (16). rvalid_o and wake_o are low.
- R2: A store or load acts only when mmio_addr_i[28:26] equals 5, and mmio_addr_i[8:3] selects the ring. Any other region value is ignored: no state changes, no wake_o pulse and no rvalid_o.
- R3: A store sets the ring tail to (data[15:0] + data[31:16]) modulo the ring size. Index bits above the ring size are dropped. A single post may cover a full ring and may wrap past the ring end.
- R4: A store copies data bit 32 into the ring's posted-tail generation, which is seen on qry_tgen_o.
- R5: Every accepted store, including one with a count of zero, raises wake_o for exactly the next cycle, with wake_ring_o set to the ring number.
- R6: A load raises rvalid_o one cycle later. rdata_o then holds {generation in bit 32, completed count in bits 31:16, head in bits 15:0}, as they stood before any update made in the same cycle as the load.
- R7: A head advance moves the head forward by one, modulo the ring size. When the head wraps to zero, the generation toggles.
- R8: A completion adds one to the ring's 16-bit completed count. The count wraps from 65535 to 0.
- R9: A flush write with flush_set_i high sets the flush flag and leaves the count unchanged. With flush_set_i low, it clears the flag and resets the count to zero. This reset wins over a completion on the same ring in the same cycle.
- R10: A configuration write sets the ring size to 2^cfg_log2_i, with values above 16 treated as 16. It resets the ring's tail, head, generation and posted generation, keeps the completed count, and takes priority over a post or head advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mmio_wr_i | input | 1 | Register store strobe |
| mmio_rd_i | input | 1 | Register load strobe |
| mmio_addr_i | input | 29 | Access address (region in 28:26, ring in 8:3) |
| mmio_wdata_i | input | 33 | Store data {gen, count, tail index} |
| mmio_rdata_o | output | 33 | Load data {gen, completed count, head} |
| mmio_rvalid_o | output | 1 | Load data valid |
| wake_o | output | 1 | Ring wake pulse after a post |
| wake_ring_o | output | 6 | Ring that was woken |
| adv_i | input | 1 | Fetcher head advance |
| adv_ring_i | input | 6 | Ring whose head advances |
| done_i | input | 1 | Descriptor completion |
| done_ring_i | input | 6 | Ring of the completion |
| flush_we_i | input | 1 | Flush flag write |
| flush_ring_i | input | 6 | Ring of the flush write |
| flush_set_i | input | 1 | New flush flag value |
| cfg_we_i | input | 1 | Ring size write |
| cfg_ring_i | input | 6 | Ring being sized |
| cfg_log2_i | input | 5 | log2 of the ring size |
| qry_ring_i | input | 6 | Ring shown on the query port |
| qry_tail_o | output | 16 | Tail of the queried ring |
| qry_tgen_o | output | 1 | Posted generation of the queried ring |
| qry_flush_o | output | 1 | Flush flag of the queried ring |

## Verification
Two pairs of events can land on the same ring in the same cycle. A completion can arrive together with a flush-clear write, and a completion can arrive together with a load. The bench drives each pair on one falling edge. It expects the clear to leave the count at zero, and it expects the load to return the count from before the completion, with a second load showing the increment. A wrapping head advance and a full-ring or wrapping post are also checked against the modulo and generation rules.

// File: rtl/tx_db_pkg.sv
package tx_db_pkg;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned LOG2_W = 5;
  localparam int unsigned ADDR_W = 29;
  localparam int unsigned DATA_W = IDX_W + CNT_W + 1;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [LOG2_W-1:0] log2_t;

  function automatic log2_t clamp_log2(log2_t lg);
    return (lg > log2_t'(IDX_W)) ? log2_t'(IDX_W) : lg;
  endfunction

  function automatic idx_t size_mask(log2_t lg);
    idx_t m;
    for (int i = 0; i < IDX_W; i++) m[i] = (i < int'(lg));
    return m;
  endfunction
endpackage

// File: rtl/tx_db_decode.sv
module tx_db_decode
  import tx_db_pkg::*;
#(
  parameter int unsigned RING_W    = 6,
  parameter int unsigned REGION_ID = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o,
  output logic [RING_W-1:0] ring_o
);
  logic hit;
  logic unused_addr;

  assign hit         = (addr_i[28:26] == 3'(REGION_ID));
  assign ring_o      = addr_i[3 +: RING_W];
  assign wr_hit_o    = wr_i & hit;
  assign rd_hit_o    = rd_i & hit;
  assign unused_addr = ^{addr_i[25:3+RING_W], addr_i[2:0]};
endmodule

// File: rtl/tx_db_ring.sv
module tx_db_ring
  import tx_db_pkg::*;
#(
  parameter int unsigned DEF_LOG2 = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  post_i,
  input  idx_t  post_idx_i,
  input  cnt_t  post_cnt_i,
  input  logic  post_gen_i,
  input  logic  adv_i,
  input  logic  done_i,
  input  logic  flush_we_i,
  input  logic  flush_set_i,
  input  logic  cfg_we_i,
  input  log2_t cfg_log2_i,
  output idx_t  tail_o,
  output idx_t  head_o,
  output cnt_t  cnt_o,
  output logic  gen_o,
  output logic  tgen_o,
  output logic  flush_o
);
  log2_t log2_q;
  idx_t  mask, tail_q, head_q, head_nx;
  cnt_t  cnt_q;
  logic  gen_q, tgen_q, flush_q;

  assign mask    = size_mask(log2_q);
  assign head_nx = (head_q + idx_t'(1)) & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      log2_q <= log2_t'(DEF_LOG2);
      tail_q <= '0;
      head_q <= '0;
      gen_q  <= 1'b0;
      tgen_q <= 1'b0;
    end else if (cfg_we_i) begin
      log2_q <= clamp_log2(cfg_log2_i);
      tail_q <= '0;
      head_q <= '0;
      gen_q  <= 1'b0;
      tgen_q <= 1'b0;
    end else begin
      if (post_i) begin
        tail_q <= (post_idx_i + idx_t'(post_cnt_i)) & mask;
        tgen_q <= post_gen_i;
      end
      if (adv_i) begin
        head_q <= head_nx;
        if (head_nx == '0) gen_q <= ~gen_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      if (flush_we_i) flush_q <= flush_set_i;
      if (flush_we_i && !flush_set_i) cnt_q <= '0;
      else if (done_i)                cnt_q <= cnt_q + cnt_t'(1);
    end
  end

  assign tail_o  = tail_q;
  assign head_o  = head_q;
  assign cnt_o   = cnt_q;
  assign gen_o   = gen_q;
  assign tgen_o  = tgen_q;
  assign flush_o = flush_q;

  // R3: pointers never leave the configured ring
  a_r3_tail_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_q & ~mask) == '0);
  // R7: wrap of the head flips the generation
  a_r7_head_wrap_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !cfg_we_i && head_q == mask) |=> (head_q == '0 && gen_q != $past(gen_q)));
  // R9: clearing the flush flag empties the count
  a_r9_flush_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_we_i && !flush_set_i) |=> (cnt_q == '0 && !flush_q));
  // R10: resize resets the pointers
  a_r10_cfg_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (tail_q == '0 && head_q == '0 && !gen_q));
endmodule

// File: rtl/tx_ring_doorbell.sv
module tx_ring_doorbell
  import tx_db_pkg::*;
#(
  parameter int unsigned RING_W    = 6,
  parameter int unsigned DEF_LOG2  = 4,
  parameter int unsigned REGION_ID = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mmio_wr_i,
  input  logic              mmio_rd_i,
  input  logic [28:0]       mmio_addr_i,
  input  logic [32:0]       mmio_wdata_i,
  output logic [32:0]       mmio_rdata_o,
  output logic              mmio_rvalid_o,
  output logic              wake_o,
  output logic [RING_W-1:0] wake_ring_o,
  input  logic              adv_i,
  input  logic [RING_W-1:0] adv_ring_i,
  input  logic              done_i,
  input  logic [RING_W-1:0] done_ring_i,
  input  logic              flush_we_i,
  input  logic [RING_W-1:0] flush_ring_i,
  input  logic              flush_set_i,
  input  logic              cfg_we_i,
  input  logic [RING_W-1:0] cfg_ring_i,
  input  logic [4:0]        cfg_log2_i,
  input  logic [RING_W-1:0] qry_ring_i,
  output logic [15:0]       qry_tail_o,
  output logic              qry_tgen_o,
  output logic              qry_flush_o
);
  localparam int unsigned NUM_RINGS = 1 << RING_W;

  logic              wr_hit, rd_hit;
  logic [RING_W-1:0] ring;
  idx_t [NUM_RINGS-1:0] tail_a, head_a;
  cnt_t [NUM_RINGS-1:0] cnt_a;
  logic [NUM_RINGS-1:0] gen_a, tgen_a, flush_a;

  tx_db_decode #(.RING_W(RING_W), .REGION_ID(REGION_ID)) u_dec (
    .addr_i(mmio_addr_i), .wr_i(mmio_wr_i), .rd_i(mmio_rd_i),
    .wr_hit_o(wr_hit), .rd_hit_o(rd_hit), .ring_o(ring)
  );

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    tx_db_ring #(.DEF_LOG2(DEF_LOG2)) u_ring (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .post_i      (wr_hit && ring == RING_W'(g)),
      .post_idx_i  (mmio_wdata_i[15:0]),
      .post_cnt_i  (mmio_wdata_i[31:16]),
      .post_gen_i  (mmio_wdata_i[32]),
      .adv_i       (adv_i && adv_ring_i == RING_W'(g)),
      .done_i      (done_i && done_ring_i == RING_W'(g)),
      .flush_we_i  (flush_we_i && flush_ring_i == RING_W'(g)),
      .flush_set_i (flush_set_i),
      .cfg_we_i    (cfg_we_i && cfg_ring_i == RING_W'(g)),
      .cfg_log2_i  (cfg_log2_i),
      .tail_o      (tail_a[g]),
      .head_o      (head_a[g]),
      .cnt_o       (cnt_a[g]),
      .gen_o       (gen_a[g]),
      .tgen_o      (tgen_a[g]),
      .flush_o     (flush_a[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mmio_rdata_o  <= '0;
      mmio_rvalid_o <= 1'b0;
      wake_o        <= 1'b0;
      wake_ring_o   <= '0;
    end else begin
      mmio_rvalid_o <= rd_hit;
      if (rd_hit) mmio_rdata_o <= {gen_a[ring], cnt_a[ring], head_a[ring]};
      wake_o <= wr_hit;
      if (wr_hit) wake_ring_o <= ring;
    end
  end

  assign qry_tail_o  = tail_a[qry_ring_i];
  assign qry_tgen_o  = tgen_a[qry_ring_i];
  assign qry_flush_o = flush_a[qry_ring_i];

  // R5: each accepted store wakes its ring on the next cycle
  a_r5_wake_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmio_wr_i && mmio_addr_i[28:26] == 3'(REGION_ID))
      |=> (wake_o && wake_ring_o == $past(mmio_addr_i[3 +: RING_W])));
  // R2: stores outside the region never wake
  a_r2_no_stray_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mmio_wr_i && mmio_addr_i[28:26] == 3'(REGION_ID)) |=> !wake_o);
  // R6: load data follows a decoded load by one cycle
  a_r6_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mmio_rvalid_o) |-> $past(mmio_rd_i && mmio_addr_i[28:26] == 3'(REGION_ID)));
endmodule

// File: tb/tx_ring_doorbell_bench.sv
module tx_ring_doorbell_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        mmio_wr_i = 0, mmio_rd_i = 0;
  logic [28:0] mmio_addr_i = '0;
  logic [32:0] mmio_wdata_i = '0, mmio_rdata_o;
  logic        mmio_rvalid_o, wake_o;
  logic [5:0]  wake_ring_o;
  logic        adv_i = 0, done_i = 0, flush_we_i = 0, flush_set_i = 0, cfg_we_i = 0;
  logic [5:0]  adv_ring_i = '0, done_ring_i = '0, flush_ring_i = '0, cfg_ring_i = '0, qry_ring_i = '0;
  logic [4:0]  cfg_log2_i = '0;
  logic [15:0] qry_tail_o;
  logic        qry_tgen_o, qry_flush_o;
  int checks = 0, errors = 0;
  logic [32:0] rd;

  always #4 clk = ~clk;

  tx_ring_doorbell u_tx_ring_doorbell (
    .clk_i(clk), .rst_ni(rst_ni), .mmio_wr_i(mmio_wr_i), .mmio_rd_i(mmio_rd_i),
    .mmio_addr_i(mmio_addr_i), .mmio_wdata_i(mmio_wdata_i), .mmio_rdata_o(mmio_rdata_o),
    .mmio_rvalid_o(mmio_rvalid_o), .wake_o(wake_o), .wake_ring_o(wake_ring_o),
    .adv_i(adv_i), .adv_ring_i(adv_ring_i), .done_i(done_i), .done_ring_i(done_ring_i),
    .flush_we_i(flush_we_i), .flush_ring_i(flush_ring_i), .flush_set_i(flush_set_i),
    .cfg_we_i(cfg_we_i), .cfg_ring_i(cfg_ring_i), .cfg_log2_i(cfg_log2_i),
    .qry_ring_i(qry_ring_i), .qry_tail_o(qry_tail_o), .qry_tgen_o(qry_tgen_o),
    .qry_flush_o(qry_flush_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] mk_addr(logic [2:0] region, logic [5:0] ring);
    return {region, 17'd0, ring, 3'd0};
  endfunction

  task automatic post(logic [2:0] region, logic [5:0] ring, logic [15:0] idx,
                      logic [15:0] cnt, logic gen);
    @(negedge clk);
    mmio_wr_i = 1; mmio_addr_i = mk_addr(region, ring); mmio_wdata_i = {gen, cnt, idx};
    @(negedge clk);
    mmio_wr_i = 0;
  endtask

  task automatic load(logic [2:0] region, logic [5:0] ring, output logic [32:0] d,
                      input logic expect_valid);
    @(negedge clk);
    mmio_rd_i = 1; mmio_addr_i = mk_addr(region, ring);
    @(negedge clk);
    mmio_rd_i = 0;
    d = mmio_rdata_o;
    check("R6 rvalid", mmio_rvalid_o, expect_valid);
  endtask

  function automatic logic [15:0] tail_of(logic [5:0] r);
    qry_ring_i = r;
    return qry_tail_o;
  endfunction

  task automatic qtail(string req, logic [5:0] r, logic [15:0] exp);
    qry_ring_i = r; #1;
    check(req, qry_tail_o, exp);
  endtask

  task automatic configure(logic [5:0] r, logic [4:0] lg);
    @(negedge clk); cfg_we_i = 1; cfg_ring_i = r; cfg_log2_i = lg;
    @(negedge clk); cfg_we_i = 0;
  endtask

  task automatic advance(logic [5:0] r, int n);
    @(negedge clk); adv_i = 1; adv_ring_i = r;
    repeat (n) @(negedge clk);
    adv_i = 0;
  endtask

  task automatic complete(logic [5:0] r, int n);
    @(negedge clk); done_i = 1; done_ring_i = r;
    repeat (n) @(negedge clk);
    done_i = 0;
  endtask

  task automatic t_reset;
    qtail("R1 tail ring0", 6'd0, 16'd0);
    qtail("R1 tail ring63", 6'd63, 16'd0);
    check("R1 tgen", qry_tgen_o, 0);
    check("R1 flush", qry_flush_o, 0);
    check("R1 rvalid", mmio_rvalid_o, 0);
    check("R1 wake", wake_o, 0);
    load(3'd5, 6'd7, rd, 1);
    check("R1 read zero", rd, 33'd0);
  endtask

  task automatic t_post;
    post(3'd5, 6'd5, 16'd3, 16'd4, 1'b0);
    check("R5 wake", wake_o, 1);
    check("R5 wake ring", wake_ring_o, 6'd5);
    qtail("R3 simple post", 6'd5, 16'd7);
    post(3'd5, 6'd5, 16'd14, 16'd5, 1'b1);
    qtail("R3 wrap post", 6'd5, 16'd3);
    check("R4 tgen set", qry_tgen_o, 1);
    post(3'd5, 6'd5, 16'd3, 16'd16, 1'b0);
    qtail("R3 full ring post", 6'd5, 16'd3);
    check("R4 tgen clear", qry_tgen_o, 0);
    post(3'd5, 6'd5, 16'h1237, 16'd1, 1'b0);
    qtail("R3 high index bits dropped", 6'd5, 16'd8);
    post(3'd5, 6'd5, 16'd9, 16'd0, 1'b0);
    check("R5 zero count wakes", wake_o, 1);
    qtail("R5 zero count tail", 6'd5, 16'd9);
    @(negedge clk);
    check("R5 single cycle pulse", wake_o, 0);
  endtask

  task automatic t_region;
    post(3'd4, 6'd5, 16'd1, 16'd1, 1'b1);
    check("R2 no wake off region", wake_o, 0);
    qtail("R2 tail untouched", 6'd5, 16'd9);
    check("R2 tgen untouched", qry_tgen_o, 0);
    load(3'd6, 6'd5, rd, 0);
    post(3'd5, 6'd6, 16'd2, 16'd3, 1'b0);
    check("R2 ring select wake", wake_ring_o, 6'd6);
    qtail("R2 ring6 tail", 6'd6, 16'd5);
    qtail("R2 ring5 unchanged", 6'd5, 16'd9);
  endtask

  task automatic t_head;
    configure(6'd10, 5'd2);
    advance(6'd10, 3);
    load(3'd5, 6'd10, rd, 1);
    check("R7 head 3", rd[15:0], 16'd3);
    check("R7 gen before wrap", rd[32], 0);
    advance(6'd10, 1);
    load(3'd5, 6'd10, rd, 1);
    check("R7 head wrap to 0", rd[15:0], 16'd0);
    check("R7 gen toggled", rd[32], 1);
  endtask

  task automatic t_done;
    complete(6'd10, 3);
    load(3'd5, 6'd10, rd, 1);
    check("R8 count 3", rd[31:16], 16'd3);
    @(negedge clk); flush_we_i = 1; flush_ring_i = 6'd10; flush_set_i = 1; qry_ring_i = 6'd10;
    @(negedge clk); flush_we_i = 0;
    check("R9 flush set", qry_flush_o, 1);
    load(3'd5, 6'd10, rd, 1);
    check("R9 set keeps count", rd[31:16], 16'd3);
    // load and completion in the same cycle
    @(negedge clk); mmio_rd_i = 1; mmio_addr_i = mk_addr(3'd5, 6'd10); done_i = 1; done_ring_i = 6'd10;
    @(negedge clk); mmio_rd_i = 0; done_i = 0;
    check("R6 pre-update count", mmio_rdata_o[31:16], 16'd3);
    load(3'd5, 6'd10, rd, 1);
    check("R6 count after", rd[31:16], 16'd4);
    // completion and flush clear in the same cycle
    @(negedge clk); done_i = 1; flush_we_i = 1; flush_set_i = 0;
    @(negedge clk); done_i = 0; flush_we_i = 0;
    check("R9 flush cleared", qry_flush_o, 0);
    load(3'd5, 6'd10, rd, 1);
    check("R9 clear beats completion", rd[31:16], 16'd0);
    complete(6'd11, 65537);
    load(3'd5, 6'd11, rd, 1);
    check("R8 count wraps", rd[31:16], 16'd1);
  endtask

  task automatic t_cfg;
    post(3'd5, 6'd5, 16'd4, 16'd1, 1'b1);
    configure(6'd5, 5'd3);
    qtail("R10 tail reset", 6'd5, 16'd0);
    check("R10 tgen reset", qry_tgen_o, 0);
    post(3'd5, 6'd5, 16'd6, 16'd5, 1'b0);
    qtail("R10 size 8", 6'd5, 16'd3);
    configure(6'd5, 5'd31);
    post(3'd5, 6'd5, 16'hFFFF, 16'd2, 1'b0);
    qtail("R10 size clamped to 2^16", 6'd5, 16'd1);
    configure(6'd11, 5'd4);
    load(3'd5, 6'd11, rd, 1);
    check("R10 count kept", rd[31:16], 16'd1);
    // config wins over same-cycle post
    @(negedge clk); cfg_we_i = 1; cfg_ring_i = 6'd5; cfg_log2_i = 5'd4;
    mmio_wr_i = 1; mmio_addr_i = mk_addr(3'd5, 6'd5); mmio_wdata_i = {1'b0, 16'd2, 16'd3};
    @(negedge clk); cfg_we_i = 0; mmio_wr_i = 0;
    qtail("R10 config beats post", 6'd5, 16'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset;
    t_post;
    t_region;
    t_head;
    t_done;
    t_cfg;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule